// File: doc/BRIEF.md
# Synthesizer Register Bus Status and Busy Model

This block is the chip-side bus front end of a synthesizer with two register ports. A host writes a register address and then a data byte on either port. The block keeps the last address written on each port. When a data byte arrives on a port whose address is set, the block passes the port, address and data onward on a one-cycle strobe.

Each accepted data write may start a busy period. The register address decides its length. Busy does not show at once: it appears a fixed number of cycles after the write. It drops when the write's full duration has passed, counted from the write itself.

Busy is visible only as the top bit of a status byte, and only through port 0. A data write that arrives while busy is showing is not passed on, and the block raises a violation strobe instead. The model suits emulation, or use as a responder when testing a controller that has to pace its register writes.

Top module: `synthBusStatus`

## Requirements
- R1: After reset the status byte reads 0x00, and fwdValid and violation are both low.
- R2: A write with wrIsData=0 stores wrByte as that port's address. A later write with wrIsData=1 on the same port raises fwdValid for exactly one cycle after the write edge, with fwdPort, fwdAddr and fwdData showing that port, the stored address and the data byte.
- R3: A data write on a port that has had no address write since reset is ignored: no fwdValid, no violation and no busy. The address stored on the other port does not count.
- R4: Busy is low for the first SET_DELAY cycles after an accepted data write edge and is high from cycle SET_DELAY onward (default 8, range 1 to 20), if the write has a busy period.
- R5: A data write to address 0x28 holds busy until cycle KEY_BUSY (default 116) after the write edge. Busy is low from that cycle on.
- R6: A data write to any address from 0x30 to 0x9E holds busy until cycle OP_BUSY (default 83).
- R7: A data write to any address from 0xA0 to 0xB6 holds busy until cycle CH_BUSY (default 47).
- R8: A data write to any other address, including 0x21 to 0x2F except 0x28, and 0x9F and 0xB7, is forwarded without a busy period. It leaves any running busy timing unchanged.
- R9: With rdEn high and rdPort=0, rdData has busy in bit 7 and zeros in bits 6:0. With rdPort=1, or with rdEn low, rdData is 0x00.
- R10: A data write while busy is high pulses violation for one cycle after the write edge. That write is not forwarded, and the running busy timing is unchanged.
- R11: An accepted data write with a busy period that arrives before busy has risen restarts the timing from the new write, using the new address's duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock; one cycle per chip cycle |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrPort | input | 1 | Target port of the write (0 or 1) |
| wrIsData | input | 1 | 0: address write, 1: data write |
| wrByte | input | 8 | Address or data byte |
| rdEn | input | 1 | Status read enable |
| rdPort | input | 1 | Port being read |
| rdData | output | 8 | Status byte (busy in bit 7) |
| fwdValid | output | 1 | One-cycle strobe for a forwarded write |
| fwdPort | output | 1 | Port of the forwarded write |
| fwdAddr | output | 8 | Register address of the forwarded write |
| fwdData | output | 8 | Data byte of the forwarded write |
| violation | output | 1 | One-cycle strobe for a data write rejected while busy |

## Verification
Two functions can land in the same cycle: a new data write arriving, and the busy timer that is already running from an earlier write. The bench provokes this in three ways. It issues a write once busy has risen, which must flag a violation and leave the fall cycle where it was. It issues a busy-starting write before busy has risen, which must restart the timing. It issues a no-busy write during the rise delay, which must leave the running timing alone. Each case is judged by reading the port 0 status on every cycle and comparing it with the rise and fall cycles worked out from the requirements.

// File: rtl/synth_bus_pkg.sv
`timescale 1ns/1ps
package synth_bus_pkg;

  // Address boundaries that select the busy length (behaviour-bearing)
  localparam logic [7:0] KEY_ADDR = 8'h28;
  localparam logic [7:0] OP_LO    = 8'h30;
  localparam logic [7:0] OP_HI    = 8'h9E;
  localparam logic [7:0] CH_LO    = 8'hA0;
  localparam logic [7:0] CH_HI    = 8'hB6;

  // Strobes from control to datapath
  typedef struct packed {
    logic addrLoad;   // store wrByte as the port's address
    logic dataGo;     // accept and forward the data write
    logic dataBad;    // reject: write arrived while busy
    logic port;       // port the strobe refers to
  } busStrobe_t;

  // Busy length for a register address; zero means no busy period
  function automatic int unsigned busyCycles(input logic [7:0] a,
                                             input int unsigned keyCyc,
                                             input int unsigned opCyc,
                                             input int unsigned chCyc);
    if (a == KEY_ADDR)              return keyCyc;
    if (a >= OP_LO && a <= OP_HI)   return opCyc;
    if (a >= CH_LO && a <= CH_HI)   return chCyc;
    return 0;
  endfunction

endpackage

// File: rtl/synth_bus_ctrl.sv
`timescale 1ns/1ps
module synth_bus_ctrl
  import synth_bus_pkg::*;
(
  input  logic       wrEn,
  input  logic       wrPort,
  input  logic       wrIsData,
  input  logic [1:0] addrValid,
  input  logic       busyNow,
  output busStrobe_t strobe
);

  logic dataReady;

  always_comb begin
    dataReady      = wrEn && wrIsData && addrValid[wrPort];
    strobe.addrLoad = wrEn && !wrIsData;
    strobe.dataGo   = dataReady && !busyNow;
    strobe.dataBad  = dataReady && busyNow;
    strobe.port     = wrPort;
  end

endmodule

// File: rtl/synth_busy_timer.sv
`timescale 1ns/1ps
module synth_busy_timer #(
  parameter int SET_DELAY = 8,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] startDur,
  output logic             busyNow
);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur;
  logic [CNT_W-1:0] cntNext;

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      dur    <= '0;
    end else if (start && startDur != '0) begin
      active <= 1'b1;
      cnt    <= '0;
      dur    <= startDur;
    end else if (active) begin
      cnt <= cntNext;
      if (cntNext >= dur) active <= 1'b0;
    end
  end

  assign busyNow = active && (cnt >= CNT_W'(SET_DELAY)) && (cnt < dur);

endmodule

// File: rtl/synth_bus_datapath.sv
`timescale 1ns/1ps
module synth_bus_datapath
  import synth_bus_pkg::*;
#(
  parameter int SET_DELAY = 8,
  parameter int KEY_BUSY  = 116,
  parameter int OP_BUSY   = 83,
  parameter int CH_BUSY   = 47,
  parameter int CNT_W     = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t strobe,
  input  logic [7:0] wrByte,
  input  logic       rdEn,
  input  logic       rdPort,
  output logic [1:0] addrValid,
  output logic       busyNow,
  output logic [7:0] rdData,
  output logic       fwdValid,
  output logic       fwdPort,
  output logic [7:0] fwdAddr,
  output logic [7:0] fwdData,
  output logic       violation
);

  logic [7:0]       addrReg [2];
  logic [7:0]       curAddr;
  logic [CNT_W-1:0] curDur;

  assign curAddr = addrReg[strobe.port];
  assign curDur  = CNT_W'(busyCycles(curAddr, KEY_BUSY, OP_BUSY, CH_BUSY));

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrReg[p]   <= '0;
        addrValid[p] <= 1'b0;
      end else if (strobe.addrLoad && strobe.port == 1'(p)) begin
        addrReg[p]   <= wrByte;
        addrValid[p] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      fwdPort   <= 1'b0;
      fwdAddr   <= '0;
      fwdData   <= '0;
      violation <= 1'b0;
    end else begin
      fwdValid  <= strobe.dataGo;
      violation <= strobe.dataBad;
      if (strobe.dataGo) begin
        fwdPort <= strobe.port;
        fwdAddr <= curAddr;
        fwdData <= wrByte;
      end
    end
  end

  synth_busy_timer #(
    .SET_DELAY(SET_DELAY),
    .CNT_W    (CNT_W)
  ) i_timer (
    .clk     (clk),
    .rstN    (rstN),
    .start   (strobe.dataGo),
    .startDur(curDur),
    .busyNow (busyNow)
  );

  assign rdData = (rdEn && !rdPort) ? {busyNow, 7'b0} : 8'h00;

endmodule

// File: rtl/synthBusStatus.sv
`timescale 1ns/1ps
module synthBusStatus
  import synth_bus_pkg::*;
#(
  parameter int SET_DELAY = 8,
  parameter int KEY_BUSY  = 116,
  parameter int OP_BUSY   = 83,
  parameter int CH_BUSY   = 47
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrPort,
  input  logic       wrIsData,
  input  logic [7:0] wrByte,
  input  logic       rdEn,
  input  logic       rdPort,
  output logic [7:0] rdData,
  output logic       fwdValid,
  output logic       fwdPort,
  output logic [7:0] fwdAddr,
  output logic [7:0] fwdData,
  output logic       violation
);

  localparam int MAX_A   = (KEY_BUSY > OP_BUSY) ? KEY_BUSY : OP_BUSY;
  localparam int MAX_DUR = (MAX_A > CH_BUSY) ? MAX_A : CH_BUSY;
  localparam int CNT_W   = $clog2(MAX_DUR + 2);

  busStrobe_t strobe;
  logic [1:0] addrValid;
  logic       busyNow;

  synth_bus_ctrl i_ctrl (
    .wrEn     (wrEn),
    .wrPort   (wrPort),
    .wrIsData (wrIsData),
    .addrValid(addrValid),
    .busyNow  (busyNow),
    .strobe   (strobe)
  );

  synth_bus_datapath #(
    .SET_DELAY(SET_DELAY),
    .KEY_BUSY (KEY_BUSY),
    .OP_BUSY  (OP_BUSY),
    .CH_BUSY  (CH_BUSY),
    .CNT_W    (CNT_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrByte   (wrByte),
    .rdEn     (rdEn),
    .rdPort   (rdPort),
    .addrValid(addrValid),
    .busyNow  (busyNow),
    .rdData   (rdData),
    .fwdValid (fwdValid),
    .fwdPort  (fwdPort),
    .fwdAddr  (fwdAddr),
    .fwdData  (fwdData),
    .violation(violation)
  );

endmodule

// File: rtl/synthBusStatus_chk.sv
`timescale 1ns/1ps
module synthBusStatus_chk
  import synth_bus_pkg::*;
#(
  parameter int SET_DELAY = 8,
  parameter int KEY_BUSY  = 116,
  parameter int OP_BUSY   = 83,
  parameter int CH_BUSY   = 47
) (
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic       rdPort,
  input logic [7:0] rdData,
  input logic       fwdValid,
  input logic [7:0] fwdAddr,
  input logic       violation,
  input logic       busyNow
);

  // cycles since the last forwarded write that had a busy period
  logic [31:0] sinceStart;

  always_ff @(posedge clk) begin
    if (!rstN) sinceStart <= '0;
    else if (fwdValid && busyCycles(fwdAddr, KEY_BUSY, OP_BUSY, CH_BUSY) != 0)
      sinceStart <= 32'd1;
    else if (sinceStart != 32'hFFFF_FFFF)
      sinceStart <= sinceStart + 32'd1;
  end

  AST_BUSY_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    busyNow |-> (sinceStart >= 32'(SET_DELAY)));  // R4

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyNow |-> (sinceStart < 32'(KEY_BUSY)));  // R5

  AST_PORT1_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdPort) |-> (rdData == 8'h00));  // R9

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6:0] == 7'd0);  // R9

  AST_FWD_XOR_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && violation));  // R10

  AST_VIOL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(busyNow));  // R10

endmodule

bind synthBusStatus synthBusStatus_chk #(
  .SET_DELAY(SET_DELAY),
  .KEY_BUSY (KEY_BUSY),
  .OP_BUSY  (OP_BUSY),
  .CH_BUSY  (CH_BUSY)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdEn     (rdEn),
  .rdPort   (rdPort),
  .rdData   (rdData),
  .fwdValid (fwdValid),
  .fwdAddr  (fwdAddr),
  .violation(violation),
  .busyNow  (busyNow)
);

// File: tb/test_synthBusStatus.sv
`timescale 1ns/1ps
module test_synthBusStatus;

  localparam int SD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, wrPort = 1'b0, wrIsData = 1'b0;
  logic [7:0] wrByte = '0;
  logic       rdEn = 1'b1, rdPort = 1'b0;
  logic [7:0] rdData;
  logic       fwdValid, fwdPort, violation;
  logic [7:0] fwdAddr, fwdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  synthBusStatus i_synthBusStatus (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPort(wrPort), .wrIsData(wrIsData),
    .wrByte(wrByte), .rdEn(rdEn), .rdPort(rdPort), .rdData(rdData),
    .fwdValid(fwdValid), .fwdPort(fwdPort), .fwdAddr(fwdAddr),
    .fwdData(fwdData), .violation(violation)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive at a negedge, returns at the negedge after the write edge (k=0)
  task automatic busWrite(input bit p, input bit d, input logic [7:0] b);
    wrEn = 1'b1; wrPort = p; wrIsData = d; wrByte = b;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // status from cycle kFrom to kTo; busy expected in [SD, dur)
  task automatic profile(input string tag, input int dur, input int kFrom, input int kTo);
    for (int k = kFrom; k <= kTo; k++) begin
      logic [7:0] exp;
      exp = (dur > 0 && k >= SD && k < dur) ? 8'h80 : 8'h00;
      check(rdData == exp, $sformatf("%s k=%0d", tag, k), rdData, exp);
      if (k != kTo) @(negedge clk);
    end
  endtask

  task automatic tReset();
    check(rdData == 8'h00, "R1 status", rdData, 0);
    check(fwdValid == 1'b0, "R1 fwdValid", fwdValid, 0);
    check(violation == 1'b0, "R1 violation", violation, 0);
  endtask

  task automatic tNoAddress();
    busWrite(1'b0, 1'b0, 8'h30);            // address on port 0 only
    busWrite(1'b1, 1'b1, 8'h55);            // port 1 has no address
    check(fwdValid == 1'b0, "R3 no fwd", fwdValid, 0);
    check(violation == 1'b0, "R3 no violation", violation, 0);
    profile("R3 no busy", 0, 0, SD + 4);
  endtask

  task automatic tRange(input string tag, input bit p, input logic [7:0] a,
                        input logic [7:0] d, input int dur);
    idle(3);
    busWrite(p, 1'b0, a);
    busWrite(p, 1'b1, d);
    check(fwdValid == 1'b1, {tag, " R2 fwdValid"}, fwdValid, 1);
    check(fwdPort == p, {tag, " R2 fwdPort"}, fwdPort, p);
    check(fwdAddr == a, {tag, " R2 fwdAddr"}, fwdAddr, a);
    check(fwdData == d, {tag, " R2 fwdData"}, fwdData, d);
    profile(tag, dur, 0, (dur > 0 ? dur : SD) + 2);
    @(negedge clk);
    check(fwdValid == 1'b0, {tag, " R2 strobe one cycle"}, fwdValid, 0);
  endtask

  task automatic tPort1Read();
    busWrite(1'b0, 1'b0, 8'h28);
    busWrite(1'b0, 1'b1, 8'h01);
    idle(SD + 2);                            // k = SD+2, busy high
    check(rdData == 8'h80, "R9 port0 busy", rdData, 8'h80);
    rdPort = 1'b1; #0.1;
    check(rdData == 8'h00, "R9 port1 zero", rdData, 0);
    rdPort = 1'b0; rdEn = 1'b0; #0.1;
    check(rdData == 8'h00, "R9 rdEn low zero", rdData, 0);
    rdEn = 1'b1;
    idle(120);
  endtask

  task automatic tViolation();
    busWrite(1'b0, 1'b0, 8'h40);
    busWrite(1'b0, 1'b1, 8'h11);             // k=0
    idle(10);                                // k=10, busy
    busWrite(1'b0, 1'b1, 8'h22);             // k=11
    check(violation == 1'b1, "R10 violation", violation, 1);
    check(fwdValid == 1'b0, "R10 not forwarded", fwdValid, 0);
    @(negedge clk);
    check(violation == 1'b0, "R10 one cycle", violation, 0);
    profile("R10 timing kept", 83, 12, 86);
    idle(3);
  endtask

  task automatic tZeroDurDuringRise();
    busWrite(1'b1, 1'b0, 8'hA0);
    busWrite(1'b1, 1'b1, 8'h33);             // k=0
    busWrite(1'b1, 1'b0, 8'h22);             // k=1
    busWrite(1'b1, 1'b1, 8'h44);             // k=2, no-busy register
    check(fwdValid == 1'b1 && fwdAddr == 8'h22, "R8 forwarded in rise", fwdAddr, 8'h22);
    profile("R8 timing kept", 47, 2, 50);
    idle(3);
  endtask

  task automatic tRestart();
    busWrite(1'b0, 1'b0, 8'hA5);
    busWrite(1'b0, 1'b1, 8'h01);             // k=0, 47-cycle write
    idle(2);                                 // k=2
    busWrite(1'b0, 1'b0, 8'h28);             // k=3
    busWrite(1'b0, 1'b1, 8'h02);             // restart, k'=0
    check(fwdValid == 1'b1, "R11 accepted", fwdValid, 1);
    profile("R11 restart", 116, 0, 118);
    idle(3);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNoAddress();
    tRange("R5 key", 1'b0, 8'h28, 8'hF0, 116);
    tRange("R6 op low", 1'b1, 8'h30, 8'h12, 83);
    tRange("R6 op high", 1'b0, 8'h9E, 8'h34, 83);
    tRange("R7 ch low", 1'b1, 8'hA0, 8'h56, 47);
    tRange("R7 ch high R4", 1'b0, 8'hB6, 8'h78, 47);
    tRange("R8 0x2F", 1'b0, 8'h2F, 8'h9A, 0);
    tRange("R8 0x9F", 1'b1, 8'h9F, 8'hBC, 0);
    tRange("R8 0xB7", 1'b0, 8'hB7, 8'hDE, 0);
    tPort1Read();
    tViolation();
    tZeroDurDuringRise();
    tRestart();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule